// File: doc/BRIEF.md
# Chip-Select External Bus Controller

This block sits between an internal requester and an external memory bus. A request carries a 24-bit byte address, a read/write flag, a byte/word size and write data. The controller compares the address with six programmable windows. It drives the chip select of the lowest-numbered window that matches and then runs one external cycle. Each cycle has a one-cycle address phase and a data phase, whose minimum length is set by the selected window's wait count. Once those waits have elapsed, the `ready` input can extend the data phase further.

Each window has a base, a compare mask, a wait count from 0 to 15, a width flag (8 or 16 bits) and an enable bit. All are written through a simple configuration port. An address that hits no window asserts no chip select but still runs a cycle with the timing and width of the last window.

On a 16-bit window the byte-high enable and address bit 0 select the lanes, and split low and high write strobes gate the writes. A word access to an 8-bit window becomes two byte cycles. When the access ends, a one-cycle `done` pulse returns the read data.

Top module: `csbus_ctrl`

## Requirements
- R1: `cs_n` has one active-low bit per window. At most one bit is low at any time, and only during the address and data phases of an external cycle. The bit stays unchanged from the address phase into the data phase.
- R2: A window matches when its enable bit is set and `(addr ^ base) & mask` is zero. The fields are written through `cfg_we`, `cfg_sel`, `cfg_base`, `cfg_mask`, `cfg_waits`, `cfg_wide` and `cfg_en`.
- R3: When several enabled windows match, the one with the lowest index drives its chip select and supplies the wait count and width.
- R4: After reset, window 0 is enabled with base FF2000h and mask FFFF00h, so it covers FF2000h to FF20FFh. All windows reset to 15 waits and 8-bit width, and windows 1 to 5 reset disabled. A read at FF2080h selects `cs_n[0]`.
- R5: With a wait count W greater than 0, the data phase lasts W+1 cycles while `ready` is high. `ready` is sampled only in the last of those cycles. While it is low there, one more data cycle is added per low sample.
- R6: With W equal to 0, the data phase lasts exactly one cycle and `ready` is ignored.
- R7: On 16-bit windows, {`bhe_n`, `ext_addr[0]`} is 0/0 for a word, 0/1 for a high-byte access and 1/0 for a low-byte access. On 8-bit windows `bhe_n` stays high. A byte write drives the byte on both lanes of a 16-bit window.
- R8: In the data phase of a write on a 16-bit window, `wrl_n` goes low for low-byte and word writes and `wrh_n` goes low for high-byte and word writes. On 8-bit windows both go low on every write.
- R9: A word access to an 8-bit window runs two byte cycles: the low byte at the word address first, then the high byte at address+1. Each cycle has its own address phase. Read data is returned as {second byte, first byte}.
- R10: An address that matches no window leaves every `cs_n` bit high, and the cycle uses window 5's wait count and width.
- R11: `adv` is high for exactly the one address-phase cycle that starts each external cycle, with no strobe active in that cycle. `rd_n` is low only in the data phase of reads.
- R12: `done` is a one-cycle pulse in the cycle after the last data phase ends. For reads, `rdata` then holds the word, or the byte zero-extended, taken from the lane selected per R7. Word requests use even addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write the window fields selected by `cfg_sel` |
| cfg_sel | input | 3 | Window index to write |
| cfg_base | input | 24 | Window base address |
| cfg_mask | input | 24 | Address bits compared against the base |
| cfg_waits | input | 4 | Minimum wait count |
| cfg_wide | input | 1 | 1 = 16-bit window, 0 = 8-bit |
| cfg_en | input | 1 | Window enable |
| req | input | 1 | Start an access (taken when idle) |
| req_addr | input | 24 | Byte address |
| req_write | input | 1 | 1 = write |
| req_word | input | 1 | 1 = 16-bit access, 0 = byte |
| req_wdata | input | 16 | Write data (byte in bits 7:0) |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read data, valid with `done` |
| ext_addr | output | 24 | External address |
| adv | output | 1 | Address-phase strobe |
| cs_n | output | 6 | Active-low chip selects |
| rd_n | output | 1 | Active-low read strobe |
| wrl_n | output | 1 | Active-low low-byte write strobe |
| wrh_n | output | 1 | Active-low high-byte write strobe |
| bhe_n | output | 1 | Active-low byte-high enable |
| ext_wdata | output | 16 | External write data |
| ext_rdata | input | 16 | External read data |
| ready | input | 1 | Cycle extension input |

## Verification
The assertions check on every cycle that at most one chip select is low and that it holds from the address phase into the data phase. They also check that `adv` lasts one cycle with no strobe beside it, that the read and write strobes never overlap, and that `done` never lasts more than one cycle. Other behaviour only shows up in the bench's scenarios, because it depends on how the windows are programmed:
- which window wins an overlap;
- how long the data phase lasts for a given wait count and `ready` pattern;
- whether `ready` is ignored at zero waits;
- how bytes are laid out on 8-bit and 16-bit windows;
- the two-step word split;
- the fall-back to window 5 settings.

// File: rtl/csbus_ctrl.sv
module csbus_ctrl #(
  parameter int NWIN = 6,
  parameter int AW = 24,
  parameter int WW = 4,
  parameter logic [AW-1:0] RST_BASE = 24'hFF2000,
  parameter logic [AW-1:0] RST_MASK = 24'hFFFF00
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_sel,
  input  logic [AW-1:0] cfg_base,
  input  logic [AW-1:0] cfg_mask,
  input  logic [WW-1:0] cfg_waits,
  input  logic          cfg_wide,
  input  logic          cfg_en,
  input  logic          req,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  input  logic          req_word,
  input  logic [15:0]   req_wdata,
  output logic          done,
  output logic [15:0]   rdata,
  output logic [AW-1:0] ext_addr,
  output logic          adv,
  output logic [NWIN-1:0] cs_n,
  output logic          rd_n,
  output logic          wrl_n,
  output logic          wrh_n,
  output logic          bhe_n,
  output logic [15:0]   ext_wdata,
  input  logic [15:0]   ext_rdata,
  input  logic          ready
);
  localparam int SW = $clog2(NWIN);

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_DATA} st_t;
  st_t st;

  logic [AW-1:0] base [NWIN];
  logic [AW-1:0] mask [NWIN];
  logic [WW-1:0] waits [NWIN];
  logic [NWIN-1:0] wide, en;

  logic [AW-1:0] a_q;
  logic          wr_q, word_q, half_q;
  logic [15:0]   wd_q, rd_q;
  logic [WW-1:0] wcnt;

  logic [SW-1:0] sel;
  logic          any;

  always_comb begin
    sel = SW'(NWIN - 1);
    any = 1'b0;
    for (int i = NWIN - 1; i >= 0; i--) begin
      if (en[i] && (((a_q ^ base[i]) & mask[i]) == '0)) begin
        sel = SW'(i);
        any = 1'b1;
      end
    end
  end

  wire [WW-1:0] w_sel   = waits[sel];
  wire          wide_s  = wide[sel];
  wire          active  = (st != S_IDLE);
  wire          in_data = (st == S_DATA);
  wire          hi_lane = wide_s && (word_q || a_q[0]);
  wire          lo_lane = !wide_s || word_q || !a_q[0];
  wire          split   = !wide_s && word_q;
  wire          finish  = in_data && (wcnt == w_sel) && ((w_sel == '0) || ready);
  wire [7:0]    in_byte = (wide_s && a_q[0]) ? ext_rdata[15:8] : ext_rdata[7:0];

  always_comb
    for (int i = 0; i < NWIN; i++)
      cs_n[i] = !(active && any && (sel == SW'(i)));

  assign ext_addr  = a_q;
  assign adv       = (st == S_ADDR);
  assign rd_n      = !(in_data && !wr_q);
  assign wrl_n     = !(in_data && wr_q && lo_lane);
  assign wrh_n     = !(in_data && wr_q && (hi_lane || !wide_s));
  assign bhe_n     = !(active && hi_lane);
  assign ext_wdata = wide_s ? (word_q ? wd_q : {wd_q[7:0], wd_q[7:0]})
                            : {8'h00, (half_q ? wd_q[15:8] : wd_q[7:0])};
  assign rdata     = rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NWIN; i++) begin
        base[i]  <= (i == 0) ? RST_BASE : '0;
        mask[i]  <= (i == 0) ? RST_MASK : '0;
        waits[i] <= '1;
        wide[i]  <= 1'b0;
        en[i]    <= (i == 0);
      end
    end else if (cfg_we && (int'(cfg_sel) < NWIN)) begin
      base[cfg_sel]  <= cfg_base;
      mask[cfg_sel]  <= cfg_mask;
      waits[cfg_sel] <= cfg_waits;
      wide[cfg_sel]  <= cfg_wide;
      en[cfg_sel]    <= cfg_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      a_q    <= '0;
      wr_q   <= 1'b0;
      word_q <= 1'b0;
      half_q <= 1'b0;
      wd_q   <= '0;
      rd_q   <= '0;
      wcnt   <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (req) begin
          a_q    <= req_addr;
          wr_q   <= req_write;
          word_q <= req_word;
          wd_q   <= req_wdata;
          half_q <= 1'b0;
          st     <= S_ADDR;
        end
        S_ADDR: begin
          wcnt <= '0;
          st   <= S_DATA;
        end
        S_DATA: begin
          if (finish) begin
            if (split && !half_q) begin
              rd_q[7:0] <= ext_rdata[7:0];
              half_q    <= 1'b1;
              a_q       <= a_q + AW'(1);
              st        <= S_ADDR;
            end else begin
              if (split)       rd_q[15:8] <= ext_rdata[7:0];
              else if (word_q) rd_q       <= ext_rdata;
              else             rd_q       <= {8'h00, in_byte};
              done <= 1'b1;
              st   <= S_IDLE;
            end
          end else if (wcnt != w_sel) begin
            wcnt <= wcnt + WW'(1);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module csbus_ctrl_chk #(
  parameter int NWIN = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NWIN-1:0] cs_n,
  input logic            adv,
  input logic            rd_n,
  input logic            wrl_n,
  input logic            wrh_n,
  input logic            done
);
  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(~cs_n)); // R1
  AST_CS_HELD: assert property (@(posedge clk) disable iff (!rst_n) adv |=> $stable(cs_n)); // R1
  AST_ADV_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) adv |=> !adv); // R11
  AST_ADV_QUIET: assert property (@(posedge clk) disable iff (!rst_n) adv |-> (rd_n && wrl_n && wrh_n)); // R11
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !rd_n |-> (wrl_n && wrh_n)); // R11
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R12
endmodule

bind csbus_ctrl csbus_ctrl_chk #(.NWIN(NWIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .adv(adv), .rd_n(rd_n),
  .wrl_n(wrl_n), .wrh_n(wrh_n), .done(done)
);

// File: tb/csbus_ctrl_tb.sv
module csbus_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        cfg_we = 0, cfg_wide = 0, cfg_en = 0;
  logic [2:0]  cfg_sel = 0;
  logic [23:0] cfg_base = 0, cfg_mask = 0;
  logic [3:0]  cfg_waits = 0;
  logic        req = 0, req_write = 0, req_word = 0, ready = 1;
  logic [23:0] req_addr = 0;
  logic [15:0] req_wdata = 0;
  logic        done, adv, rd_n, wrl_n, wrh_n, bhe_n;
  logic [15:0] rdata, ext_wdata, ext_rdata;
  logic [23:0] ext_addr;
  logic [5:0]  cs_n;
  logic        cur_wide = 0;

  int checks = 0, fails = 0;

  logic [23:0] m_base [6];
  logic [23:0] m_mask [6];
  logic [3:0]  m_w [6];
  logic        m_wide [6];
  logic        m_en [6];

  function automatic logic [7:0] bval(input logic [23:0] x);
    return x[7:0] ^ x[15:8] ^ 8'hA5;
  endfunction

  assign ext_rdata = cur_wide ? {bval({ext_addr[23:1], 1'b1}), bval({ext_addr[23:1], 1'b0})}
                              : {8'h00, bval(ext_addr)};

  csbus_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_base(cfg_base),
    .cfg_mask(cfg_mask), .cfg_waits(cfg_waits), .cfg_wide(cfg_wide), .cfg_en(cfg_en),
    .req(req), .req_addr(req_addr), .req_write(req_write), .req_word(req_word),
    .req_wdata(req_wdata), .done(done), .rdata(rdata), .ext_addr(ext_addr), .adv(adv),
    .cs_n(cs_n), .rd_n(rd_n), .wrl_n(wrl_n), .wrh_n(wrh_n), .bhe_n(bhe_n),
    .ext_wdata(ext_wdata), .ext_rdata(ext_rdata), .ready(ready)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic cfgw(input int i, input logic [23:0] b, input logic [23:0] m,
                      input logic [3:0] w, input logic wd, input logic e);
    @(negedge clk);
    cfg_we = 1; cfg_sel = 3'(i); cfg_base = b; cfg_mask = m; cfg_waits = w;
    cfg_wide = wd; cfg_en = e;
    m_base[i] = b; m_mask[i] = m; m_w[i] = w; m_wide[i] = wd; m_en[i] = e;
    @(negedge clk);
    cfg_we = 0;
  endtask

  // bus vector: {cs_n, adv, rd_n, wrl_n, wrh_n, bhe_n}
  task automatic access(input string tag, input logic [23:0] a, input logic wr,
                        input logic word, input logic [15:0] wd, input int extra);
    int s = 5;
    logic hit = 0;
    int W, halves, nd;
    logic wide;
    logic [5:0] cs_exp;
    logic [15:0] exp_rd;
    for (int i = 5; i >= 0; i--)
      if (m_en[i] && (((a ^ m_base[i]) & m_mask[i]) == 0)) begin s = i; hit = 1; end
    W = m_w[s];
    wide = m_wide[s];
    cur_wide = wide;
    halves = (!wide && word) ? 2 : 1;
    cs_exp = hit ? ~(6'b1 << s) : 6'h3F;
    nd = W + ((W > 0) ? extra : 0) + 1;
    @(negedge clk);
    req = 1; req_addr = a; req_write = wr; req_word = word; req_wdata = wd;
    for (int h = 0; h < halves; h++) begin
      logic [23:0] ca = a + 24'(h);
      logic hi = wide && (word || ca[0]);
      logic lo = !wide || word || !ca[0];
      @(negedge clk);
      req = 0;
      check({tag, " addr phase bus (R1 R11)"}, {cs_n, adv, rd_n, wrl_n, wrh_n, bhe_n},
            {cs_exp, 1'b1, 1'b1, 1'b1, 1'b1, !hi});
      check({tag, " ext_addr (R9)"}, ext_addr, ca);
      for (int k = 0; k < nd; k++) begin
        @(negedge clk);
        ready = (W == 0) ? 1'b0 : (k >= W + extra);
        check({tag, " data phase bus (R5 R6 R7 R8 R10)"}, {cs_n, adv, rd_n, wrl_n, wrh_n, bhe_n},
              {cs_exp, 1'b0, wr, !(wr && lo), !(wr && (hi || !wide)), !hi});
        if (wr)
          check({tag, " write lanes (R7 R9)"}, ext_wdata,
                wide ? (word ? wd : {wd[7:0], wd[7:0]}) : {8'h00, (h == 1 ? wd[15:8] : wd[7:0])});
      end
    end
    @(negedge clk);
    ready = 1;
    exp_rd = word ? {bval(a + 24'd1), bval(a)} : {8'h00, bval(a)};
    check({tag, " done pulse (R12)"}, {done, cs_n, adv, rd_n, wrl_n, wrh_n}, {1'b1, 6'h3F, 1'b0, 3'b111});
    if (!wr) check({tag, " read data (R12)"}, rdata, exp_rd);
    @(negedge clk);
    check({tag, " done drops (R12)"}, done, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 6; i++) begin
      m_base[i] = 0; m_mask[i] = 0; m_w[i] = 4'hF; m_wide[i] = 0; m_en[i] = (i == 0);
    end
    m_base[0] = 24'hFF2000; m_mask[0] = 24'hFFFF00;
    repeat (3) @(negedge clk);
    check("reset bus R1", {cs_n, adv, rd_n, wrl_n, wrh_n, bhe_n, done}, {6'h3F, 1'b0, 4'hF, 1'b0});
    rst_n = 1;
    // R4: boot window, 15 waits, 8-bit
    access("R4 boot read FF2080", 24'hFF2080, 0, 0, 0, 0);
    access("R4 boot outside FF2180 uses window 5 (R10)", 24'hFF2180, 0, 0, 0, 0);
    // R2 R6: 16-bit zero-wait window, ready held low
    cfgw(1, 24'h010000, 24'hFF0000, 4'd0, 1, 1);
    access("R6 word read zero wait", 24'h010010, 0, 1, 0, 0);
    access("R7 high byte read", 24'h010011, 0, 0, 0, 0);
    access("R7 low byte read", 24'h010012, 0, 0, 0, 0);
    // R5 R8: 16-bit window with waits and ready extension
    cfgw(2, 24'h020000, 24'hFFF000, 4'd2, 1, 1);
    access("R5 word write extra3", 24'h020100, 1, 1, 16'hBEEF, 3);
    access("R8 high byte write", 24'h020103, 1, 0, 16'h005A, 0);
    access("R8 low byte write", 24'h020104, 1, 0, 16'h00C3, 1);
    access("R5 word read extra0", 24'h020200, 0, 1, 0, 0);
    // R9: 8-bit window word split
    cfgw(3, 24'h030000, 24'hFF0000, 4'd1, 0, 1);
    access("R9 split word write", 24'h030040, 1, 1, 16'h1234, 2);
    access("R9 split word read", 24'h030080, 0, 1, 0, 1);
    access("R8 8-bit byte write", 24'h030081, 1, 0, 16'h0077, 0);
    // R10: unmatched address uses window 5 settings
    cfgw(5, 24'h400000, 24'hFF0000, 4'd3, 1, 0);
    access("R10 unmatched word read", 24'h500000, 0, 1, 0, 1);
    access("R10 unmatched byte read odd", 24'h500005, 0, 0, 0, 0);
    // R3: overlapping windows, lowest index wins
    cfgw(4, 24'h010000, 24'hFFFF00, 4'd5, 0, 1);
    access("R3 overlap picks window 1", 24'h010020, 0, 0, 0, 0);
    cfgw(1, 24'h010000, 24'hFF0000, 4'd0, 1, 0);
    access("R2 disabled window falls to window 4", 24'h010021, 0, 0, 0, 1);
    summary();
    $finish;
  end
endmodule